// File: doc/BRIEF.md
# Branch Target Buffer with Return Stack

This block sits beside the fetch stage and predicts where fetch goes next. The fetch address is looked up in a direct-mapped table, and in the same cycle the block reports whether a known branch lives there, whether it is predicted taken, its predicted target and the resulting next fetch address. When there is no usable prediction, the next fetch address is the sequential address.

Each table slot holds a valid bit, an address tag, a target, a 2-bit saturating direction counter and a branch kind. The branch kind is conditional, call, return or jump. Conditional branches follow their counter. The other three kinds are always predicted taken. For a slot marked as a return, the target comes from a small stack of return addresses when that stack holds an entry.

Branches are reported back through a single resolve port. Each report carries the branch address, the actual direction, the actual target and the branch kind. Reports train the counters, allocate new slots and drive pushes and pops of the return stack.

Top module: `fetch_target_predictor`

## Requirements
- R1: Address bits [7:2] select one of 64 slots and bits [31:8] are compared with that slot's stored tag. On a tag mismatch or an invalid slot, pred_hit_o=0, pred_taken_o=0 and next_pc_o=fetch_pc_i+4.
- R2: The lookup is combinational in fetch_pc_i. pred_hit_o, pred_taken_o, pred_target_o and next_pc_o all describe the current fetch_pc_i in the same cycle. When pred_taken_o=1, next_pc_o equals pred_target_o.
- R3: The direction counter uses the encoding 00, 01, 10, 11. A conditional slot predicts taken when its counter is 10 or 11 and predicts not-taken when it is 00 or 01.
- R4: A resolve that hits a slot raises the counter by one when taken and lowers it by one when not taken. The counter holds at 11 and at 00. A conditional prediction therefore flips only after two wrong outcomes in a row from a strong state.
- R5: A taken resolve that misses the table fills the slot. It records the tag, the actual target and the kind, and sets the counter to 10. A not-taken resolve that misses leaves the table unchanged.
- R6: A taken resolve that hits replaces the slot's target with the reported target and replaces its kind with the reported kind.
- R7: upd_kind_i and the stored kind use the encoding 00 = conditional, 01 = call, 10 = return, 11 = jump. Call, return and jump slots predict taken whatever their counter holds.
- R8: A resolve of kind call pushes upd_pc_i+4 onto the return stack. A resolve of kind return pops the stack. A hit on a return slot predicts the top of the stack as its target.
- R9: The return stack holds 8 addresses. A push onto a full stack overwrites the oldest entry. For example, after nine pushes, eight pops return the last eight addresses newest-first and leave the stack empty.
- R10: A hit on a return slot while the stack is empty predicts the slot's stored target. A pop from an empty stack has no effect.
- R11: Reset invalidates every slot and empties the return stack.
- R12: A resolve becomes visible to lookups from the next cycle onward. A lookup made in the same cycle sees the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | Fetch address to look up |
| upd_valid_i | input | 1 | Resolve report valid |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction |
| upd_target_i | input | 32 | Actual target |
| upd_kind_i | input | 2 | Branch kind (00 cond, 01 call, 10 return, 11 jump) |
| pred_hit_o | output | 1 | Fetch address matches a valid slot |
| pred_taken_o | output | 1 | Predicted taken |
| pred_target_o | output | 32 | Predicted target (valid when hit) |
| next_pc_o | output | 32 | Predicted next fetch address |

## Verification
Directed sequences walk one conditional slot through every counter state in both directions, including repeated outcomes at each saturation end. They also probe addresses that share an index but differ in tag, which separates a correct tag compare from an index-only lookup. Call and return sequences drive the stack empty, partly full and past full. This exposes wrong push values, wrong pop order and wrong fallback to the table target. A long pseudo-random stream then mixes kinds, directions and aliasing addresses against a behavioural model. That stream catches update-ordering faults, such as a lookup that sees a resolve from the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    KIND_COND = 2'b00,
    KIND_CALL = 2'b01,
    KIND_RET  = 2'b10,
    KIND_JUMP = 2'b11
  } br_kind_e;

  localparam logic [1:0] CTR_ALLOC = 2'b10;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic [1:0]        lk_ctr_o,
  output logic [ADDR_W-1:0] lk_target_o,
  output br_kind_e          lk_kind_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  br_kind_e          upd_kind_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic              vld_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [ADDR_W-1:0] tgt_q  [ENTRIES];
  logic [1:0]        ctr_q  [ENTRIES];
  br_kind_e          kind_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             up_hit;

  assign lk_idx = lk_pc_i[IDX_W+1:2];
  assign lk_tag = lk_pc_i[ADDR_W-1:IDX_W+2];
  assign up_idx = upd_pc_i[IDX_W+1:2];
  assign up_tag = upd_pc_i[ADDR_W-1:IDX_W+2];

  assign lk_hit_o    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_ctr_o    = ctr_q[lk_idx];
  assign lk_target_o = tgt_q[lk_idx];
  assign lk_kind_o   = kind_q[lk_idx];

  assign up_hit = vld_q[up_idx] && (tag_q[up_idx] == up_tag);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = upd_valid_i && (up_idx == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        tag_q[e]  <= '0;
        tgt_q[e]  <= '0;
        ctr_q[e]  <= '0;
        kind_q[e] <= KIND_COND;
      end else if (sel) begin
        if (up_hit) begin
          ctr_q[e] <= ctr_step(ctr_q[e], upd_taken_i);
          if (upd_taken_i) begin
            tgt_q[e]  <= upd_target_i;
            kind_q[e] <= upd_kind_i;
          end
        end else if (upd_taken_i) begin
          // allocate, weakly taken
          vld_q[e]  <= 1'b1;
          tag_q[e]  <= up_tag;
          tgt_q[e]  <= upd_target_i;
          ctr_q[e]  <= CTR_ALLOC;
          kind_q[e] <= upd_kind_i;
        end
      end
    end
  end

endmodule

// File: rtl/btb_ras.sv
module btb_ras #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [ADDR_W-1:0]          push_addr_i,
  output logic [ADDR_W-1:0]          top_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, top_ptr;
  logic [CNT_W-1:0]  cnt_q;

  assign top_ptr = (wr_ptr_q == '0) ? LAST : wr_ptr_q - 1'b1;
  assign top_o   = mem_q[top_ptr];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      // full stack: pointer wraps onto the oldest slot
      mem_q[wr_ptr_q] <= push_addr_i;
      wr_ptr_q        <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      wr_ptr_q <= top_ptr;
      cnt_q    <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 64,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [1:0]        upd_kind_i,
  output logic              pred_hit_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  br_kind_e          upd_kind, lk_kind;
  logic              lk_hit;
  logic [1:0]        lk_ctr;
  logic [ADDR_W-1:0] lk_target, ras_top;
  logic              ras_empty, ras_push, ras_pop;
  logic [CNT_W-1:0]  ras_cnt;

  assign upd_kind = br_kind_e'(upd_kind_i);

  btb_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_pc_i      (fetch_pc_i),
    .lk_hit_o     (lk_hit),
    .lk_ctr_o     (lk_ctr),
    .lk_target_o  (lk_target),
    .lk_kind_o    (lk_kind),
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_taken_i  (upd_taken_i),
    .upd_target_i (upd_target_i),
    .upd_kind_i   (upd_kind)
  );

  assign ras_push = upd_valid_i && (upd_kind == KIND_CALL);
  assign ras_pop  = upd_valid_i && (upd_kind == KIND_RET);

  btb_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ras_push),
    .pop_i       (ras_pop),
    .push_addr_i (upd_pc_i + STEP),
    .top_o       (ras_top),
    .empty_o     (ras_empty),
    .cnt_o       (ras_cnt)
  );

  always_comb begin
    pred_hit_o    = lk_hit;
    pred_taken_o  = lk_hit && ((lk_kind != KIND_COND) || lk_ctr[1]);
    pred_target_o = (lk_kind == KIND_RET && !ras_empty) ? ras_top : lk_target;
    next_pc_o     = pred_taken_o ? pred_target_o : fetch_pc_i + STEP;
  end

endmodule

// File: rtl/fetch_target_predictor_checker.sv
module fetch_target_predictor_checker #(
  parameter int ADDR_W    = 32,
  parameter int RAS_DEPTH = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              fetch_pc_i,
  input logic                           upd_valid_i,
  input logic [ADDR_W-1:0]              upd_pc_i,
  input logic                           upd_taken_i,
  input logic [1:0]                     upd_kind_i,
  input logic                           pred_hit_o,
  input logic                           pred_taken_o,
  input logic [ADDR_W-1:0]              pred_target_o,
  input logic [ADDR_W-1:0]              next_pc_o,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_cnt
);
  a_r1_miss_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> (!pred_taken_o && next_pc_o == fetch_pc_i + ADDR_W'(4)));

  a_r2_taken_uses_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> (pred_hit_o && next_pc_o == pred_target_o));

  a_r5_alloc_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=> (fetch_pc_i == $past(upd_pc_i)) |-> pred_hit_o);

  a_r8_call_fills_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_kind_i == 2'b01) |=> ras_cnt != '0);

  a_r9_stack_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_cnt <= ($clog2(RAS_DEPTH+1))'(RAS_DEPTH));

  a_r10_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_kind_i == 2'b10 && ras_cnt == '0) |=> ras_cnt == '0);

endmodule

bind fetch_target_predictor fetch_target_predictor_checker #(
  .ADDR_W(ADDR_W), .RAS_DEPTH(RAS_DEPTH)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_pc_i    (fetch_pc_i),
  .upd_valid_i   (upd_valid_i),
  .upd_pc_i      (upd_pc_i),
  .upd_taken_i   (upd_taken_i),
  .upd_kind_i    (upd_kind_i),
  .pred_hit_o    (pred_hit_o),
  .pred_taken_o  (pred_taken_o),
  .pred_target_o (pred_target_o),
  .next_pc_o     (next_pc_o),
  .ras_cnt       (ras_cnt)
);

// File: tb/fetch_target_predictor_tb_top.sv
`timescale 1ns/1ps
module fetch_target_predictor_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [31:0] upd_target_i = '0;
  logic [1:0]  upd_kind_i = '0;
  logic        pred_hit_o, pred_taken_o;
  logic [31:0] pred_target_o, next_pc_o;

  always #2 clk_i = ~clk_i;

  fetch_target_predictor dut_i (
    .clk_i, .rst_ni, .fetch_pc_i, .upd_valid_i, .upd_pc_i, .upd_taken_i,
    .upd_target_i, .upd_kind_i, .pred_hit_o, .pred_taken_o, .pred_target_o, .next_pc_o
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference
  bit          m_v   [64];
  logic [23:0] m_tag [64];
  logic [31:0] m_tgt [64];
  int          m_ctr [64];
  int          m_kind[64];
  logic [31:0] m_ras [$];

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0; m_kind[i] = 0;
    end
    m_ras.delete();
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic [31:0] pc, bit uv = 0, logic [31:0] upc = 0,
                      bit ut = 0, logic [31:0] utgt = 0, int uk = 0);
    int idx;
    bit hit, tk;
    logic [31:0] tgt, nxt;
    @(negedge clk_i);
    fetch_pc_i = pc; upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    upd_target_i = utgt; upd_kind_i = 2'(uk);
    #1;
    idx = int'(pc[7:2]);
    hit = m_v[idx] && (m_tag[idx] == pc[31:8]);
    tk  = hit && (m_kind[idx] != 0 || m_ctr[idx] >= 2);
    tgt = (m_kind[idx] == 2 && m_ras.size() > 0) ? m_ras[$] : m_tgt[idx];
    nxt = tk ? tgt : pc + 32'd4;
    chk(req, "hit", 32'(pred_hit_o), 32'(hit));
    chk(req, "taken", 32'(pred_taken_o), 32'(tk));
    chk(req, "next_pc", next_pc_o, nxt);
    if (hit) chk(req, "target", pred_target_o, tgt);
    if (uv) begin
      idx = int'(upc[7:2]);
      if (m_v[idx] && m_tag[idx] == upc[31:8]) begin
        m_ctr[idx] = ut ? (m_ctr[idx] == 3 ? 3 : m_ctr[idx] + 1)
                        : (m_ctr[idx] == 0 ? 0 : m_ctr[idx] - 1);
        if (ut) begin m_tgt[idx] = utgt; m_kind[idx] = uk; end
      end else if (ut) begin
        m_v[idx] = 1; m_tag[idx] = upc[31:8]; m_tgt[idx] = utgt;
        m_ctr[idx] = 2; m_kind[idx] = uk;
      end
      if (uk == 1) begin
        m_ras.push_back(upc + 32'd4);
        if (m_ras.size() > 8) void'(m_ras.pop_front());
      end else if (uk == 2 && m_ras.size() > 0) begin
        void'(m_ras.pop_back());
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R11: empty after reset
    step("R11", 32'h0000_1000);
    step("R11", 32'h0000_0100);
    // R12: same-cycle lookup sees old state; R5 allocation
    step("R12", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 0);
    step("R5", 32'h0000_1000);
    // R1: same index, different tag
    step("R1", 32'h0000_1100);
    step("R1", 32'h0001_1000);
    // R3 R4: counter walk
    step("R4", 32'h0000_1000, 1, 32'h0000_1000, 0, 0, 0);
    step("R3", 32'h0000_1000, 1, 32'h0000_1000, 0, 0, 0);
    step("R4", 32'h0000_1000, 1, 32'h0000_1000, 0, 0, 0);
    step("R4", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 0);
    step("R3", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 0);
    step("R4", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 0);
    step("R4", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 0);
    step("R4", 32'h0000_1000, 1, 32'h0000_1000, 0, 0, 0);
    step("R4", 32'h0000_1000);
    // R5: not-taken miss allocates nothing
    step("R5", 32'h0000_3000, 1, 32'h0000_3000, 0, 32'h0000_3800, 0);
    step("R5", 32'h0000_3000);
    // R6: retarget on taken hit
    step("R6", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2400, 0);
    step("R6", 32'h0000_1000);
    // R7: jump stays taken at counter 00
    step("R7", 32'h0000_3400, 1, 32'h0000_3400, 1, 32'h0000_9000, 3);
    for (int i = 0; i < 3; i++) step("R7", 32'h0000_3400, 1, 32'h0000_3400, 0, 0, 3);
    step("R7", 32'h0000_3400);
    // R8 R10: call/return
    step("R8", 32'h0000_4000, 1, 32'h0000_4000, 1, 32'h0000_5000, 1);
    step("R8", 32'h0000_5100, 1, 32'h0000_5100, 1, 32'h0000_4004, 2);
    step("R10", 32'h0000_5100);
    step("R10", 32'h0000_5100, 1, 32'h0000_5100, 1, 32'h0000_4004, 2);
    step("R10", 32'h0000_5100);
    step("R8", 32'h0000_5100, 1, 32'h0000_4800, 1, 32'h0000_5000, 1);
    step("R8", 32'h0000_5100);
    // R9: overflow, then drain newest-first
    for (int i = 0; i < 9; i++)
      step("R9", 32'h0000_5100, 1, 32'h0000_6000 + 32'(i * 16), 1, 32'h0000_5000, 1);
    for (int i = 0; i < 10; i++)
      step("R9", 32'h0000_5100, 1, 32'h0000_5100, 1, 32'h0000_4004, 2);
    step("R9", 32'h0000_5100);

    // R2: mixed pseudo-random stream with aliasing addresses
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] a, b;
      a = {20'h0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 7)), 4'h0};
      b = {20'h0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 7)), 4'h0};
      step("R2", a, 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 1)),
           32'($urandom_range(0, 255)) << 4, int'($urandom_range(0, 3)));
    end

    // R11: reset mid-run clears everything
    @(negedge clk_i) rst_ni = 1'b0;
    upd_valid_i = 1'b0;
    model_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    step("R11", 32'h0000_1000);
    step("R11", 32'h0000_5100);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule